// File: doc/BRIEF.md
# Flash Reset and Supply Lockout Sequencer

This block sits between the external reset pin, a supply monitor and the embedded program/erase engine of a NOR flash controller. It decides when the array may be touched again after a reset, and it shuts the host out of the device while the supply is too low. It does not sense any voltage and does not run any algorithm. The supply monitor gives a single "supply above lockout" flag. The engine is seen only through a busy input and an abort pulse.

A reset from the pin, or a supply drop, stops the engine with a single abort pulse and holds the command logic in its cleared state. The block then counts an internal ready time. That time is longer when the engine was busy at entry, and only in that case is the ready/busy line pulled low for the whole interval. Once the pin has been back high for a separate recovery interval, and the internal reset has finished, host reads and writes pass again. While the supply is low, write cycles are dropped in the same cycle they arrive. All intervals are parameters counted in clock cycles.

Top module: `flash_rst_lockout`

## Requirements
- R1: The reset pin passes through two synchronizing flops. A pin change therefore acts after the second rising edge that samples it, and no earlier. With the pin held high through and after system reset, host access opens on the (T_READ_REC+2)-th edge after system reset is released.
- R2: Each entry into the reset condition produces exactly one cycle of `engine_abort`, on the cycle after entry. The reset condition is pin low or supply low. A supply drop while the pin already holds reset produces no second pulse.
- R3: If `engine_busy` is 1 on the entry edge, `rb_drive_low` stays 1 for exactly T_READY_BUSY cycles starting with the abort cycle. This holds even if the pin is released earlier, and access stays closed until that interval has ended.
- R4: If `engine_busy` is 0 on the entry edge, `rb_drive_low` stays 0 through the whole reset. The internal reset then takes T_READY_IDLE cycles.
- R5: After the synchronized pin returns high, `rd_grant` stays 0 for T_READ_REC cycles and opens on the (T_READ_REC+2)-th edge after the pin rises.
- R6: While `supply_ok` is 0, `wr_accept` and `rd_grant` are 0 in the same cycle, whatever `wr_req` and `rd_req` do.
- R7: After `supply_ok` returns to 1 with the pin high, writes stay ignored for T_READ_REC cycles. They are accepted from the T_READ_REC-th edge on.
- R8: `cmd_clear` is 1 in every cycle in which the pin (as synchronized) or the supply holds reset, and 0 otherwise.
- R9: Outside reset and recovery, `wr_accept` equals `wr_req`, `rd_grant` equals `rd_req`, and `rb_drive_low` equals `engine_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the block's own flops |
| hw_rst_n | input | 1 | Asynchronous active-low flash reset pin |
| supply_ok | input | 1 | 1 while the supply is above the write lockout level |
| engine_busy | input | 1 | Program/erase engine is running |
| wr_req | input | 1 | Host write cycle request |
| rd_req | input | 1 | Host read cycle request |
| wr_accept | output | 1 | Write cycle passed to the command logic |
| rd_grant | output | 1 | Read cycle allowed to the array |
| engine_abort | output | 1 | One-cycle stop request to the engine |
| cmd_clear | output | 1 | Holds the command and unlock state cleared |
| rb_drive_low | output | 1 | Pull the open-drain ready/busy line low (busy) |

## Verification
The supply path is combinational, so lockout gating of `wr_accept` and `rd_grant` is due in the same cycle. The abort follows one edge later. The pin path carries two synchronizer edges before gating and one more before the abort and the ready hold. Access reopens on edge T_READ_REC+2 after the pin rises, and on edge T_READ_REC after the supply returns. The bench drives every input one time unit after a rising edge and samples one time unit after the edge that should produce a change. At each boundary it checks the cycle before as closed and the cycle at the boundary as open, so an off-by-one in any counter is caught.

// File: rtl/flash_rl_pkg.sv
package flash_rl_pkg;

  // Internal reset length; a zero is raised to one and the busy case never
  // runs shorter than the idle case.
  function automatic int unsigned ready_cycles(input bit was_busy,
                                               input int unsigned t_busy,
                                               input int unsigned t_idle);
    int unsigned idle_n;
    int unsigned busy_n;
    idle_n = (t_idle < 1) ? 1 : t_idle;
    busy_n = (t_busy < idle_n) ? idle_n : t_busy;
    return was_busy ? busy_n : idle_n;
  endfunction

  // Read recovery after the pin is released, at least one cycle.
  function automatic int unsigned recovery_cycles(input int unsigned t_rec);
    return (t_rec < 1) ? 1 : t_rec;
  endfunction

endpackage

// File: rtl/flash_rl_sync.sv
module flash_rl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/flash_rl_downcnt.sv
module flash_rl_downcnt #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= RST_VAL;
    else if (load)  cnt <= load_val;
    else if (!zero) cnt <= cnt - 1'b1;
endmodule

// File: rtl/flash_rst_lockout.sv
module flash_rst_lockout
  import flash_rl_pkg::*;
#(
  parameter int unsigned T_READY_BUSY = 20,
  parameter int unsigned T_READY_IDLE = 5,
  parameter int unsigned T_READ_REC   = 3,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic hw_rst_n,
  input  logic supply_ok,
  input  logic engine_busy,
  input  logic wr_req,
  input  logic rd_req,
  output logic wr_accept,
  output logic rd_grant,
  output logic engine_abort,
  output logic cmd_clear,
  output logic rb_drive_low
);
  localparam int unsigned BUSY_LD = ready_cycles(1'b1, T_READY_BUSY, T_READY_IDLE);
  localparam int unsigned IDLE_LD = ready_cycles(1'b0, T_READY_BUSY, T_READY_IDLE);
  localparam int unsigned REC_LD  = recovery_cycles(T_READ_REC);
  localparam int unsigned CNT_MAX = (BUSY_LD > REC_LD) ? BUSY_LD : REC_LD;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] BUSY_V = CNT_W'(BUSY_LD);
  localparam logic [CNT_W-1:0] IDLE_V = CNT_W'(IDLE_LD);
  localparam logic [CNT_W-1:0] REC_V  = CNT_W'(REC_LD);

  // Named internal events, also watched by the checker.
  logic             pin_ok;      // synchronized pin, 1 = released
  logic             rst_active;  // pin or supply holds reset
  logic             in_rst_q;    // rst_active one cycle ago
  logic             entry;       // first cycle of a reset condition
  logic             abort_q;
  logic             hold_busy_q; // engine was running at entry
  logic [CNT_W-1:0] rdy_cnt;
  logic             rdy_zero;
  logic [CNT_W-1:0] rec_cnt;
  logic             rec_zero;
  logic             access_ok;

  flash_rl_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk  (clk),
    .rst_n(sys_rst_n),
    .d    (hw_rst_n),
    .q    (pin_ok)
  );

  assign rst_active = ~pin_ok | ~supply_ok;
  assign entry      = rst_active & ~in_rst_q;

  always_ff @(posedge clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      in_rst_q    <= 1'b1;
      abort_q     <= 1'b0;
      hold_busy_q <= 1'b0;
    end else begin
      in_rst_q <= rst_active;
      abort_q  <= entry;
      if (entry) hold_busy_q <= engine_busy;
    end

  // Internal reset time, picked at entry from the engine state.
  flash_rl_downcnt #(.W(CNT_W), .RST_VAL('0)) u_ready_cnt (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .load    (entry),
    .load_val(engine_busy ? BUSY_V : IDLE_V),
    .cnt     (rdy_cnt),
    .zero    (rdy_zero)
  );

  // Read recovery: held full while in reset, runs out after release.
  flash_rl_downcnt #(.W(CNT_W), .RST_VAL(REC_V)) u_rec_cnt (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .load    (rst_active),
    .load_val(REC_V),
    .cnt     (rec_cnt),
    .zero    (rec_zero)
  );

  assign access_ok    = ~rst_active & rdy_zero & rec_zero;
  assign wr_accept    = wr_req & access_ok;
  assign rd_grant     = rd_req & access_ok;
  assign engine_abort = abort_q;
  assign cmd_clear    = rst_active;
  assign rb_drive_low = (hold_busy_q & ~rdy_zero) | (engine_busy & ~in_rst_q);
endmodule

// File: rtl/flash_rst_lockout_chk.sv
module flash_rst_lockout_chk (
  input logic clk,
  input logic sys_rst_n,
  input logic supply_ok,
  input logic engine_busy,
  input logic wr_accept,
  input logic rd_grant,
  input logic engine_abort,
  input logic rb_drive_low,
  input logic rst_active
);
  a_r2_abort_single: assert property (@(posedge clk) disable iff (!sys_rst_n)
    engine_abort |=> !engine_abort);

  a_r2_abort_after_reset: assert property (@(posedge clk) disable iff (!sys_rst_n)
    engine_abort |-> $past(rst_active));

  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (engine_abort && $past(engine_busy)) |-> rb_drive_low);

  a_r4_idle_no_pull: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (engine_abort && !$past(engine_busy)) |-> !rb_drive_low);

  a_r5_recovery_gap: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rd_grant |-> !$past(rst_active));

  a_r6_lock_blocks: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !supply_ok |-> (!wr_accept && !rd_grant));
endmodule

bind flash_rst_lockout flash_rst_lockout_chk u_chk (
  .clk         (clk),
  .sys_rst_n   (sys_rst_n),
  .supply_ok   (supply_ok),
  .engine_busy (engine_busy),
  .wr_accept   (wr_accept),
  .rd_grant    (rd_grant),
  .engine_abort(engine_abort),
  .rb_drive_low(rb_drive_low),
  .rst_active  (rst_active)
);

// File: tb/flash_rst_lockout_bench.sv
`timescale 1ns/1ps
module flash_rst_lockout_bench;
  localparam int TB = 20;
  localparam int TI = 5;
  localparam int TR = 3;

  logic clk = 1'b0;
  logic sys_rst_n, hw_rst_n, supply_ok, engine_busy, wr_req, rd_req;
  logic wr_accept, rd_grant, engine_abort, cmd_clear, rb_drive_low;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  flash_rst_lockout #(.T_READY_BUSY(TB), .T_READY_IDLE(TI), .T_READ_REC(TR))
  u_flash_rst_lockout (
    .clk(clk), .sys_rst_n(sys_rst_n), .hw_rst_n(hw_rst_n), .supply_ok(supply_ok),
    .engine_busy(engine_busy), .wr_req(wr_req), .rd_req(rd_req),
    .wr_accept(wr_accept), .rd_grant(rd_grant), .engine_abort(engine_abort),
    .cmd_clear(cmd_clear), .rb_drive_low(rb_drive_low)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // {wr_req, rd_req, engine_busy, exp_wr, exp_rd, exp_rb}
  localparam logic [5:0] VEC [8] = '{
    6'b000_000, 6'b100_100, 6'b010_010, 6'b001_001,
    6'b110_110, 6'b011_011, 6'b101_101, 6'b111_111
  };

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    sys_rst_n = 0; hw_rst_n = 1; supply_ok = 1; engine_busy = 0;
    wr_req = 0; rd_req = 1;
    repeat (3) tick();
    chk("R8 reset cmd_clear", cmd_clear, 1'b1);
    chk("R1 reset abort", engine_abort, 1'b0);
    chk("R1 reset rb", rb_drive_low, 1'b0);
    chk("R1 reset rd", rd_grant, 1'b0);
    sys_rst_n = 1;
    repeat (TR + 1) tick();
    chk("R1 power-up still closed", rd_grant, 1'b0);
    tick();
    chk("R1 power-up open", rd_grant, 1'b1);
    chk("R8 cmd_clear low", cmd_clear, 1'b0);

    // R9: normal pass-through table
    for (int i = 0; i < 8; i++) begin
      {wr_req, rd_req, engine_busy} = VEC[i][5:3];
      #1;
      chk("R9 wr", wr_accept, VEC[i][2]);
      chk("R9 rd", rd_grant, VEC[i][1]);
      chk("R9 rb", rb_drive_low, VEC[i][0]);
      tick();
    end

    // R4/R5/R1: pin reset with engine idle
    wr_req = 0; rd_req = 1; engine_busy = 0;
    hw_rst_n = 0;
    tick();
    chk("R1 not yet synced", rd_grant, 1'b1);
    tick();
    chk("R1 synced closes rd", rd_grant, 1'b0);
    chk("R8 cmd_clear in reset", cmd_clear, 1'b1);
    chk("R2 no abort before entry", engine_abort, 1'b0);
    tick();
    chk("R2 abort pulse", engine_abort, 1'b1);
    chk("R4 idle no pull", rb_drive_low, 1'b0);
    tick();
    chk("R2 abort one cycle", engine_abort, 1'b0);
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R4 idle rb stays high", rb_drive_low, 1'b0);
    end
    hw_rst_n = 1;
    repeat (TR + 1) tick();
    chk("R5 recovery closed", rd_grant, 1'b0);
    tick();
    chk("R5 recovery open", rd_grant, 1'b1);

    // R3: pin reset while engine busy, pin released early
    engine_busy = 1;
    hw_rst_n = 0;
    tick();
    tick();
    chk("R3 rb before entry", rb_drive_low, 1'b1);
    tick();
    chk("R2 abort busy entry", engine_abort, 1'b1);
    chk("R3 rb at entry", rb_drive_low, 1'b1);
    engine_busy = 0;
    tick();
    hw_rst_n = 1;
    for (int k = 2; k < TB; k++) begin
      tick();
      chk("R3 rb held", rb_drive_low, 1'b1);
    end
    chk("R3 access closed in ready time", rd_grant, 1'b0);
    tick();
    chk("R3 rb released", rb_drive_low, 1'b0);
    chk("R3 access open", rd_grant, 1'b1);

    // R6/R7/R2: supply lockout
    wr_req = 1; rd_req = 1;
    tick();
    chk("R9 write before lockout", wr_accept, 1'b1);
    supply_ok = 0;
    #1;
    chk("R6 write dropped", wr_accept, 1'b0);
    chk("R6 read dropped", rd_grant, 1'b0);
    chk("R8 cmd_clear lockout", cmd_clear, 1'b1);
    tick();
    chk("R2 lockout abort", engine_abort, 1'b1);
    tick();
    chk("R2 lockout abort ends", engine_abort, 1'b0);
    hw_rst_n = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2 no second abort", engine_abort, 1'b0);
      chk("R6 write dropped in lockout", wr_accept, 1'b0);
    end
    hw_rst_n = 1;
    repeat (3) tick();
    chk("R6 still locked", wr_accept, 1'b0);
    supply_ok = 1;
    #1;
    chk("R7 write after supply back", wr_accept, 1'b0);
    repeat (TR - 1) tick();
    chk("R7 write still ignored", wr_accept, 1'b0);
    tick();
    chk("R7 write accepted", wr_accept, 1'b1);
    chk("R8 cmd_clear off", cmd_clear, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule